// File: doc/BRIEF.md
# Host Address Decoder Commit Bank

This block holds a set of host-physical-address decoder programming slots. Each slot has a control word, a 64-bit base, a 64-bit size, and a 64-bit auxiliary value. In the switch build, the auxiliary value is a list of up to eight downstream port identifiers. In the endpoint build, it is a skip length. Software reaches every field through a single 32-bit word-addressed register port, and each 64-bit value is split into a low word and a high word.

Programming a slot is not complete until software asks the block to commit it. The block then checks the programming. After a fixed number of clock cycles it reports one of two outcomes: committed, or commit-error. Slots must be committed strictly in ascending order. A slot that is committed with its lock bit set refuses every further write until reset.

Top module: `hpa_decoder_bank`

## Requirements
- R1: After reset, every slot reads as all zero: control, base, size and auxiliary words. The `busy` vector is zero.
- R2: Word address 0 is a read-only capability word, laid out as follows:
  - bits 7:0 hold the slot count;
  - bits 11:8 hold the target count (zero in the endpoint build);
  - bit 12 is set when address bits 11:8 may select an interleave way;
  - bit 13 is set when address bits 14:12 may select an interleave way.
- R3: Slot i occupies word addresses 8(i+1) to 8(i+1)+7, and its words read back as written:
  - +0 is the control word;
  - +1/+2 hold the base, low then high;
  - +3/+4 hold the size, low then high;
  - +5/+6 hold the auxiliary value, low then high. Target-list way k sits in bits 8k+7:8k of the 64-bit value.
  - Offset +7, and any address outside the map, reads zero.
- R4: The control word is laid out as follows:
  - bits 3:0 hold the interleave granularity;
  - bits 7:4 hold the interleave-ways code (code n means 2^n ways);
  - bit 8 is lock;
  - bit 9 is commit request;
  - bit 10 is committed status (read-only);
  - bit 11 is commit-error status (read-only);
  - bit 12 is target type (1 = memory expander, 0 = accelerator).
- R5: A control write that raises bit 9 from 0 to 1 starts a commit. Exactly COMMIT_LAT clock edges after the write edge, either committed or commit-error is set. `busy[i]` is high from the write until that outcome, and neither status bit is set while it is high.
- R6: A commit of slot i>0 ends in commit-error if slot i-1 is not committed at the edge of the request, or at the edge of completion. If slot i-1 completes on the same edge as the request, it counts as not committed.
- R7: A commit ends in commit-error in any of these cases:
  - the ways code is above 3;
  - in the switch build, the number of ways exceeds the target count;
  - the size is not a multiple of 256 MB times the number of ways.
- R8: A control write that drops bit 9 from 1 to 0 clears committed and commit-error, and aborts a pending commit. Base and size may then be rewritten, for example to zero.
- R9: While a slot is committed with lock set, writes to any of its words leave that slot unchanged and its status stays committed.
- R10: Committed and commit-error are never set together in one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Word address, shared by reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| busy | output | NUM_DEC | Per-slot commit-in-progress flag |

## Verification
The commit of slot i-1 can complete on the same clock edge on which software requests the commit of slot i. The bench provokes this by writing the request for slot 1 exactly COMMIT_LAT edges after the request for slot 0. Slot 0 must then read committed, and slot 1 must end in commit-error, because the order check sees slot 0's state from before that edge. The bench then repeats the request for slot 1 one edge later and expects it to succeed.

// File: rtl/hpa_decoder_bank.sv
module hpa_decoder_bank #(
  parameter int NUM_DEC        = 4,
  parameter int COMMIT_LAT     = 16,
  parameter bit SWITCH_FLAVOUR = 1'b1,
  parameter int TARGET_COUNT   = 8,
  parameter bit IL_BITS_11_8   = 1'b1,
  parameter bit IL_BITS_14_12  = 1'b0,
  localparam int ADDR_W = $clog2(NUM_DEC + 1) + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [NUM_DEC-1:0] busy
);
  localparam int BLK_W = ADDR_W - 3;
  localparam int CNT_W = $clog2(COMMIT_LAT + 1);

  logic [63:0]      base_q [NUM_DEC];
  logic [63:0]      size_q [NUM_DEC];
  logic [63:0]      aux_q  [NUM_DEC];
  logic [3:0]       gran_q [NUM_DEC];
  logic [3:0]       ways_q [NUM_DEC];
  logic [CNT_W-1:0] cnt_q  [NUM_DEC];
  logic [NUM_DEC-1:0] lock_q, commit_q, type_q, done_q, err_q, pend_q, bad_q;
  logic [NUM_DEC-1:0] hit, start, stop;
  logic [NUM_DEC:0]   chain;

  wire [BLK_W-1:0] blk = reg_addr[ADDR_W-1:3];
  wire [2:0]       off = reg_addr[2:0];

  assign chain = {done_q, 1'b1};
  assign busy  = pend_q;

  wire [31:0] cap_word = {18'b0, IL_BITS_14_12, IL_BITS_11_8,
                          4'(SWITCH_FLAVOUR ? TARGET_COUNT : 0), 8'(NUM_DEC)};

  function automatic logic cfg_bad(input logic [3:0] w, input logic [63:0] s);
    logic [63:0] mask;
    if (w > 4'd3) return 1'b1;
    if (SWITCH_FLAVOUR && ((32'd1 << w) > TARGET_COUNT)) return 1'b1;
    mask = (64'd1 << (28 + int'(w))) - 64'd1;
    return (s & mask) != 64'd0;
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_DEC; i++) begin
      hit[i]   = reg_wr && (blk == BLK_W'(i + 1)) && !(done_q[i] && lock_q[i]);
      start[i] = hit[i] && (off == 3'd0) && reg_wdata[9] && !commit_q[i];
      stop[i]  = hit[i] && (off == 3'd0) && !reg_wdata[9] && commit_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DEC; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
        aux_q[i]  <= '0;
        gran_q[i] <= '0;
        ways_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
      lock_q   <= '0;
      commit_q <= '0;
      type_q   <= '0;
      done_q   <= '0;
      err_q    <= '0;
      pend_q   <= '0;
      bad_q    <= '0;
    end else begin
      for (int i = 0; i < NUM_DEC; i++) begin
        if (hit[i]) begin
          case (off)
            3'd0: begin
              gran_q[i]   <= reg_wdata[3:0];
              ways_q[i]   <= reg_wdata[7:4];
              lock_q[i]   <= reg_wdata[8];
              commit_q[i] <= reg_wdata[9];
              type_q[i]   <= reg_wdata[12];
            end
            3'd1: base_q[i][31:0]  <= reg_wdata;
            3'd2: base_q[i][63:32] <= reg_wdata;
            3'd3: size_q[i][31:0]  <= reg_wdata;
            3'd4: size_q[i][63:32] <= reg_wdata;
            3'd5: aux_q[i][31:0]   <= reg_wdata;
            3'd6: aux_q[i][63:32]  <= reg_wdata;
            default: ;
          endcase
        end
        if (start[i]) begin
          pend_q[i] <= 1'b1;
          done_q[i] <= 1'b0;
          err_q[i]  <= 1'b0;
          cnt_q[i]  <= CNT_W'(COMMIT_LAT - 1);
          bad_q[i]  <= cfg_bad(reg_wdata[7:4], size_q[i]) || !chain[i];
        end else if (stop[i]) begin
          pend_q[i] <= 1'b0;
          done_q[i] <= 1'b0;
          err_q[i]  <= 1'b0;
        end else if (pend_q[i]) begin
          if (cnt_q[i] == '0) begin
            pend_q[i] <= 1'b0;
            if (bad_q[i] || !chain[i]) err_q[i] <= 1'b1;
            else                       done_q[i] <= 1'b1;
          end else begin
            cnt_q[i] <= cnt_q[i] - 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (blk == '0) begin
      if (off == 3'd0) reg_rdata = cap_word;
    end else begin
      for (int i = 0; i < NUM_DEC; i++) begin
        if (blk == BLK_W'(i + 1)) begin
          case (off)
            3'd0: reg_rdata = {19'b0, type_q[i], err_q[i], done_q[i], commit_q[i],
                               lock_q[i], ways_q[i], gran_q[i]};
            3'd1: reg_rdata = base_q[i][31:0];
            3'd2: reg_rdata = base_q[i][63:32];
            3'd3: reg_rdata = size_q[i][31:0];
            3'd4: reg_rdata = size_q[i][63:32];
            3'd5: reg_rdata = aux_q[i][31:0];
            3'd6: reg_rdata = aux_q[i][63:32];
            default: reg_rdata = '0;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_chk
    a_r10_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_q[g] && err_q[g]));
    a_r5_outcome_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done_q[g]) || $rose(err_q[g])) |-> $past(pend_q[g]));
    a_r5_busy_no_status: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[g] |-> (!done_q[g] && !err_q[g]));
    a_r6_in_order: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q[g]) |-> $past(chain[g]));
    a_r9_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(done_q[g] && lock_q[g]) |->
        (done_q[g] && $stable(base_q[g]) && $stable(size_q[g]) && $stable(aux_q[g])));
  end
endmodule

// File: tb/hpa_decoder_bank_bench.sv
module hpa_decoder_bank_bench;
  localparam int LAT = 5;
  localparam int ND  = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [ND-1:0] busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hpa_decoder_bank #(.NUM_DEC(ND), .COMMIT_LAT(LAT), .SWITCH_FLAVOUR(1'b1),
                     .TARGET_COUNT(4), .IL_BITS_11_8(1'b1), .IL_BITS_14_12(1'b0))
    u_hpa_decoder_bank (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
                        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy));

  typedef struct packed { logic w; logic [5:0] a; logic [31:0] d; } step_t;
  localparam int NSTEP = 14;
  localparam step_t TBL [NSTEP] = '{
    '{1'b1, 6'd9,  32'h0000_0000}, '{1'b1, 6'd10, 32'h0000_0001},
    '{1'b1, 6'd11, 32'h0000_0000}, '{1'b1, 6'd12, 32'h0000_0001},
    '{1'b1, 6'd13, 32'h0302_0100}, '{1'b1, 6'd14, 32'h0706_0504},
    '{1'b0, 6'd9,  32'h0000_0000}, '{1'b0, 6'd10, 32'h0000_0001},
    '{1'b0, 6'd11, 32'h0000_0000}, '{1'b0, 6'd12, 32'h0000_0001},
    '{1'b0, 6'd13, 32'h0302_0100}, '{1'b0, 6'd14, 32'h0706_0504},
    '{1'b0, 6'd15, 32'h0000_0000}, '{1'b0, 6'd63, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [5:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 / R2 reset and capability
    peek(6'd0, v);  check("R2 capability word", v, 32'h0000_1404);
    peek(6'd8, v);  check("R1 reset ctrl", v, 32'h0);
    peek(6'd11, v); check("R1 reset size", v, 32'h0);
    check("R1 reset busy", 32'(busy), 32'h0);

    // R3 table walk
    for (int k = 0; k < NSTEP; k++) begin
      if (TBL[k].w) wr(TBL[k].a, TBL[k].d);
      else begin
        @(negedge clk);
        peek(TBL[k].a, v);
        check("R3 readback", v, TBL[k].d);
      end
    end

    // R6 slot 1 before slot 0 committed
    wr(6'd19, 32'h1000_0000);
    wr(6'd16, 32'h0000_1200);
    idle(LAT);
    peek(6'd16, v); check("R6 out of order error", v, 32'h0000_1A00);
    wr(6'd16, 32'h0000_1000);
    peek(6'd16, v); check("R8 clear error", v, 32'h0000_1000);

    // R6 same-edge: slot 1 request on slot 0 completion edge
    wr(6'd8, 32'h0000_1212);
    check("R5 busy after request", 32'(busy), 32'h1);
    peek(6'd8, v); check("R4 ctrl pending", v, 32'h0000_1212);
    idle(LAT - 2);
    wr(6'd16, 32'h0000_1200);
    peek(6'd8, v); check("R5 slot0 committed", v, 32'h0000_1612);
    idle(LAT);
    peek(6'd16, v); check("R6 same-edge error", v, 32'h0000_1A00);
    wr(6'd16, 32'h0000_1000);
    wr(6'd16, 32'h0000_1200);
    idle(LAT);
    peek(6'd16, v); check("R6 in-order commit", v, 32'h0000_1600);

    // R7 validation on slot 2
    wr(6'd27, 32'h1000_0000);
    wr(6'd24, 32'h0000_1210);
    idle(LAT);
    peek(6'd24, v); check("R7 misaligned size", v, 32'h0000_1A10);
    wr(6'd24, 32'h0000_1000);
    wr(6'd27, 32'h4000_0000);
    wr(6'd24, 32'h0000_1250);
    idle(LAT);
    peek(6'd24, v); check("R7 reserved ways", v, 32'h0000_1A50);
    wr(6'd24, 32'h0000_1000);
    wr(6'd27, 32'h8000_0000);
    wr(6'd24, 32'h0000_1230);
    idle(LAT);
    peek(6'd24, v); check("R7 ways over target count", v, 32'h0000_1A30);
    wr(6'd24, 32'h0000_1000);

    // R5 exact latency with a valid slot 2 commit
    wr(6'd24, 32'h0000_1220);
    check("R5 busy slot2", 32'(busy), 32'h4);
    idle(LAT - 1);
    peek(6'd24, v); check("R5 not early", v, 32'h0000_1220);
    check("R5 busy held", 32'(busy), 32'h4);
    idle(1);
    peek(6'd24, v); check("R5 committed on time", v, 32'h0000_1620);
    check("R5 busy released", 32'(busy), 32'h0);

    // R9 lock on slot 3
    wr(6'd35, 32'h1000_0000);
    wr(6'd32, 32'h0000_1300);
    idle(LAT);
    peek(6'd32, v); check("R9 locked commit", v, 32'h0000_1700);
    wr(6'd33, 32'h0000_DEAD);
    peek(6'd33, v); check("R9 base write ignored", v, 32'h0);
    wr(6'd35, 32'h0);
    peek(6'd35, v); check("R9 size write ignored", v, 32'h1000_0000);
    wr(6'd32, 32'h0);
    peek(6'd32, v); check("R9 ctrl write ignored", v, 32'h0000_1700);

    // R8 decommit slot 2 and zero its range
    wr(6'd24, 32'h0000_1020);
    peek(6'd24, v); check("R8 committed cleared", v, 32'h0000_1020);
    wr(6'd27, 32'h0);
    wr(6'd28, 32'h0);
    peek(6'd27, v); check("R8 size zeroed", v, 32'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule